// File: doc/BRIEF.md
# Serial Control Register Loader

This block is the programming front end of a frequency synthesizer. A host drives three wires: a serial clock, a data line and a load-enable line. Each rising serial-clock edge appends one data bit to a 24-bit word, most significant bit first. A rising load-enable edge then commits the word to one of four internal latches. The two lowest bits of the word select the latch.

The latches hold a reference divide value with its companions (backlash width, test bits, lock precision), a feedback divide value with a gain bit, and a control set. The control set has two power-down bits, a counter-reset bit, an output-mux select, a timer field and two current codes. A separate initialization address writes the same control set as the function address and also raises a one-clock pulse. The three serial lines are oversampled in the system clock domain. A two-flop synchronizer and an edge detector drive both shifting and committing.

Top module: `sreg_loader`

## Requirements
- R1: While reset is sampled high, every field output is zero and the initialization pulse is low.
- R2: The word is the last 24 data bits sampled on serial-clock rising edges, first bit in the MSB (bit 23). Bits shifted in earlier drop out.
- R3: Serial-clock activity without a load-enable rising edge leaves every field output unchanged.
- R4: Address 00 (bits 1:0) loads reference divide = bits 15:2, backlash width = bits 17:16, test bits = bits 19:18, lock precision = bit 20.
- R5: Address 01 loads feedback divide = bits 20:8 and gain = bit 21.
- R6: Address 10 loads the control set: counter reset = bit 2, power-down A = bit 3, mux select = bits 6:4, timer = bits 14:11, current 1 = bits 17:15, current 2 = bits 20:18, power-down B = bit 21. The initialization pulse stays low.
- R7: Address 11 loads the control set with the R6 layout and raises the initialization pulse for exactly one clock.
- R8: A commit changes only the latch it addresses. The other latches keep their values.
- R9: Synchronous timing: a level first sampled at clock edge k acts at edge k+2. A shift or commit made at edge k+2 is visible on the outputs right after that edge.
- R10: Holding load enable high commits once only. Bits shifted while it stays high take effect only at its next rising edge.
- R11: Bits of the word outside the fields of the addressed latch have no effect on its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| le_i | input | 1 | Load enable, asynchronous |
| ref_div_o | output | 14 | Reference divide value |
| abp_width_o | output | 2 | Anti-backlash width code |
| test_mode_o | output | 2 | Test-mode bits |
| lock_prec_o | output | 1 | Lock-detect precision |
| fb_div_o | output | 13 | Feedback divide value |
| cp_gain_o | output | 1 | Charge-pump gain select |
| ctr_rst_o | output | 1 | Counter reset |
| pd_a_o | output | 1 | Power-down bit A |
| mux_sel_o | output | 3 | Output-mux select |
| timer_o | output | 4 | Timer-counter field |
| cur1_o | output | 3 | Current setting 1 |
| cur2_o | output | 3 | Current setting 2 |
| pd_b_o | output | 1 | Power-down bit B |
| init_pulse_o | output | 1 | One-clock pulse on an initialization write |

## Verification
A wire level the bench drives before clock edge k moves the field outputs at edge k+2. The initialization pulse is high only in the cycle that follows that edge. The bench reference model takes its inputs at each rising edge and delays them by two edges in a queue. It compares all outputs at the next falling edge, so the model and the design always refer to the same edge. The direct checks are timed to match: each waits three falling edges after load enable rises before it reads a field. The latency check reads the outputs at the first, second and third falling edges and expects the old, old and new values.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  parameter int WORD_W = 24;
  parameter int REF_W  = 14;
  parameter int FB_W   = 13;
  parameter int MUX_W  = 3;
  parameter int TMR_W  = 4;
  parameter int CUR_W  = 3;

  localparam int REF_LSB  = 2;
  localparam int ABP_LSB  = REF_LSB + REF_W;
  localparam int TEST_LSB = ABP_LSB + 2;
  localparam int LDP_BIT  = TEST_LSB + 2;
  localparam int FB_LSB   = 8;
  localparam int GAIN_BIT = FB_LSB + FB_W;
  localparam int CRST_BIT = 2;
  localparam int PDA_BIT  = 3;
  localparam int MUX_LSB  = 4;
  localparam int TMR_LSB  = 11;
  localparam int CUR1_LSB = TMR_LSB + TMR_W;
  localparam int CUR2_LSB = CUR1_LSB + CUR_W;
  localparam int PDB_BIT  = CUR2_LSB + CUR_W;

  typedef enum logic [1:0] {
    DST_REF  = 2'b00,
    DST_FB   = 2'b01,
    DST_FUNC = 2'b10,
    DST_INIT = 2'b11
  } dst_e;

  typedef struct packed {
    logic [REF_W-1:0] div;
    logic [1:0]       abp;
    logic [1:0]       test;
    logic             ldp;
  } ref_t;

  typedef struct packed {
    logic [FB_W-1:0] div;
    logic            gain;
  } fb_t;

  typedef struct packed {
    logic             crst;
    logic             pda;
    logic [MUX_W-1:0] mux;
    logic [TMR_W-1:0] tmr;
    logic [CUR_W-1:0] cur1;
    logic [CUR_W-1:0] cur2;
    logic             pdb;
  } fn_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sreg_edge.sv
module sreg_edge #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/sreg_shifter.sv
module sreg_shifter #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] word_o
);
  always_ff @(posedge clk) begin
    if (rst)          word_o <= '0;
    else if (shift_i) word_o <= {word_o[WIDTH-2:0], bit_i};
  end
endmodule

// File: rtl/sreg_latch_bank.sv
module sreg_latch_bank
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output ref_t              ref_o,
  output fb_t               fb_o,
  output fn_t               fn_o,
  output logic              init_o
);
  dst_e dst;
  fn_t  fn_dec;
  logic rsvd_unused;

  assign dst         = dst_e'(word_i[1:0]);
  assign rsvd_unused = ^word_i[WORD_W-1 -: 2];

  always_comb begin
    fn_dec.crst = word_i[CRST_BIT];
    fn_dec.pda  = word_i[PDA_BIT];
    fn_dec.mux  = word_i[MUX_LSB +: MUX_W];
    fn_dec.tmr  = word_i[TMR_LSB +: TMR_W];
    fn_dec.cur1 = word_i[CUR1_LSB +: CUR_W];
    fn_dec.cur2 = word_i[CUR2_LSB +: CUR_W];
    fn_dec.pdb  = word_i[PDB_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_o  <= '0;
      fb_o   <= '0;
      fn_o   <= '0;
      init_o <= 1'b0;
    end else begin
      init_o <= 1'b0;
      if (commit_i) begin
        unique case (dst)
          DST_REF: begin
            ref_o.div  <= word_i[REF_LSB +: REF_W];
            ref_o.abp  <= word_i[ABP_LSB +: 2];
            ref_o.test <= word_i[TEST_LSB +: 2];
            ref_o.ldp  <= word_i[LDP_BIT];
          end
          DST_FB: begin
            fb_o.div  <= word_i[FB_LSB +: FB_W];
            fb_o.gain <= word_i[GAIN_BIT];
          end
          DST_FUNC: fn_o <= fn_dec;
          DST_INIT: begin
            fn_o   <= fn_dec;
            init_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sreg_loader.sv
module sreg_loader
  import sreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             le_i,
  output logic [REF_W-1:0] ref_div_o,
  output logic [1:0]       abp_width_o,
  output logic [1:0]       test_mode_o,
  output logic             lock_prec_o,
  output logic [FB_W-1:0]  fb_div_o,
  output logic             cp_gain_o,
  output logic             ctr_rst_o,
  output logic             pd_a_o,
  output logic [MUX_W-1:0] mux_sel_o,
  output logic [TMR_W-1:0] timer_o,
  output logic [CUR_W-1:0] cur1_o,
  output logic [CUR_W-1:0] cur2_o,
  output logic             pd_b_o,
  output logic             init_pulse_o
);
  localparam int SCLK_IX = 0;
  localparam int DATA_IX = 1;
  localparam int LE_IX   = 2;

  logic [2:0]        pins_s;
  logic [1:0]        rise;
  logic              sclk_rise;
  logic              le_rise;
  logic [WORD_W-1:0] sh_word;
  ref_t              ref_q;
  fb_t               fb_q;
  fn_t               fn_q;

  sreg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({le_i, sdata_i, sclk_i}),
    .q_o(pins_s)
  );

  sreg_edge #(.WIDTH(2)) u_edge (
    .clk(clk), .rst(rst),
    .lvl_i({pins_s[LE_IX], pins_s[SCLK_IX]}),
    .rise_o(rise)
  );

  assign sclk_rise = rise[0];
  assign le_rise   = rise[1];

  sreg_shifter #(.WIDTH(WORD_W)) u_shift (
    .clk(clk), .rst(rst),
    .shift_i(sclk_rise),
    .bit_i(pins_s[DATA_IX]),
    .word_o(sh_word)
  );

  sreg_latch_bank u_bank (
    .clk(clk), .rst(rst),
    .commit_i(le_rise),
    .word_i(sh_word),
    .ref_o(ref_q),
    .fb_o(fb_q),
    .fn_o(fn_q),
    .init_o(init_pulse_o)
  );

  assign ref_div_o   = ref_q.div;
  assign abp_width_o = ref_q.abp;
  assign test_mode_o = ref_q.test;
  assign lock_prec_o = ref_q.ldp;
  assign fb_div_o    = fb_q.div;
  assign cp_gain_o   = fb_q.gain;
  assign ctr_rst_o   = fn_q.crst;
  assign pd_a_o      = fn_q.pda;
  assign mux_sel_o   = fn_q.mux;
  assign timer_o     = fn_q.tmr;
  assign cur1_o      = fn_q.cur1;
  assign cur2_o      = fn_q.cur2;
  assign pd_b_o      = fn_q.pdb;
endmodule

// File: rtl/sreg_loader_chk.sv
module sreg_loader_chk (
  input logic        clk,
  input logic        rst,
  input logic        le_rise,
  input logic [23:0] word,
  input logic [13:0] ref_div,
  input logic [12:0] fb_div,
  input logic [2:0]  mux_sel,
  input logic        init_pulse
);
  // R1
  rst_zero_chk: assert property (@(posedge clk)
    rst |=> (ref_div == '0 && fb_div == '0 && mux_sel == '0 && !init_pulse));

  // R3
  hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
    !le_rise |=> ($stable(ref_div) && $stable(fb_div) && $stable(mux_sel)));

  // R4
  ref_load_chk: assert property (@(posedge clk) disable iff (rst)
    (le_rise && word[1:0] == 2'b00) |=> ref_div == $past(word[15:2]));

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    init_pulse |=> !init_pulse);

  // R6
  init_source_chk: assert property (@(posedge clk) disable iff (rst)
    init_pulse |-> ($past(le_rise) && $past(word[1:0]) == 2'b11));

  // R8
  ref_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (le_rise && word[1:0] != 2'b00) |=> $stable(ref_div));
endmodule

bind sreg_loader sreg_loader_chk u_chk (
  .clk(clk), .rst(rst), .le_rise(le_rise), .word(sh_word),
  .ref_div(ref_div_o), .fb_div(fb_div_o), .mux_sel(mux_sel_o),
  .init_pulse(init_pulse_o)
);

// File: tb/sim_sreg_loader.sv
module sim_sreg_loader;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, le = 1'b0;
  logic [13:0] ref_div; logic [1:0] abp, test; logic ldp;
  logic [12:0] fb_div; logic gain;
  logic crst, pda, pdb; logic [2:0] mux, cur1, cur2; logic [3:0] tmr;
  logic init_p;

  int checks = 0, errs = 0, init_hi = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sreg_loader u0 (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdata), .le_i(le),
    .ref_div_o(ref_div), .abp_width_o(abp), .test_mode_o(test), .lock_prec_o(ldp),
    .fb_div_o(fb_div), .cp_gain_o(gain), .ctr_rst_o(crst), .pd_a_o(pda),
    .mux_sel_o(mux), .timer_o(tmr), .cur1_o(cur1), .cur2_o(cur2), .pd_b_o(pdb),
    .init_pulse_o(init_p)
  );

  // Behavioural reference model: inputs act two edges after they are sampled
  logic [2:0]  hist [$];
  logic [23:0] m_word;
  logic [18:0] m_ref;
  logic [13:0] m_fb;
  logic [15:0] m_fn;
  logic        m_init;

  function automatic logic [15:0] fn_of(logic [23:0] w);
    return {w[2], w[3], w[6:4], w[14:11], w[17:15], w[20:18], w[21]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      hist = '{3'b000, 3'b000, 3'b000};
      m_word = '0; m_ref = '0; m_fb = '0; m_fn = '0; m_init = 1'b0;
    end else begin
      logic [2:0] cur, prv;
      logic [23:0] w0;
      hist.push_back({le, sdata, sclk});
      while (hist.size() > 4) void'(hist.pop_front());
      cur = hist[hist.size()-3];
      prv = hist[hist.size()-4];
      w0 = m_word;
      m_init = 1'b0;
      if (cur[0] && !prv[0]) m_word = {m_word[22:0], cur[1]};
      if (cur[2] && !prv[2]) begin
        case (w0[1:0])
          2'b00: m_ref = {w0[15:2], w0[17:16], w0[19:18], w0[20]};
          2'b01: m_fb = {w0[20:8], w0[21]};
          2'b10: m_fn = fn_of(w0);
          default: begin m_fn = fn_of(w0); m_init = 1'b1; end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (init_p) init_hi++;
    if (!rst) begin
      logic [49:0] act, exp;
      act = {ref_div, abp, test, ldp, fb_div, gain,
             crst, pda, mux, tmr, cur1, cur2, pdb, init_p};
      exp = {m_ref, m_fb, m_fn, m_init};
      checks++;
      if (act !== exp) begin
        errs++;
        $display("FAIL R9 cycle model t=%0t actual=%h expected=%h", $time, act, exp);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [63:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = v[i]; sclk = 1'b0; wait_n(2);
      sclk = 1'b1; wait_n(2);
    end
    sclk = 1'b0; wait_n(2);
  endtask

  task automatic commit();
    le = 1'b1; wait_n(3);
    le = 1'b0; wait_n(3);
  endtask

  task automatic write_word(logic [23:0] w);
    send_bits({40'd0, w}, 24);
    commit();
  endtask

  function automatic logic [23:0] mk_ref(logic [13:0] d, logic [1:0] a, logic [1:0] t,
                                         logic l, logic [2:0] rsv);
    return {rsv, l, t, a, d, 2'b00};
  endfunction

  function automatic logic [23:0] mk_fn(logic [1:0] ad, logic c, logic pa, logic [2:0] m,
                                        logic [3:0] tm, logic [2:0] c1, logic [2:0] c2,
                                        logic pb, logic [3:0] mid);
    return {2'b11, pb, c2, c1, tm, mid, m, pa, c, ad};
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int base;
    logic [23:0] wa, wb;
    wait_n(3);
    // R1: reset state
    chk("R1 ref_div", 32'(ref_div), 0);
    chk("R1 fb_div", 32'(fb_div), 0);
    chk("R1 fn/init", 32'({crst, pda, mux, tmr, cur1, cur2, pdb, init_p}), 0);
    rst = 1'b0; wait_n(2);

    // R4, R11: reference latch with reserved bits set
    write_word(mk_ref(14'h2A5B, 2'b01, 2'b10, 1'b1, 3'b111));
    chk("R4 ref_div", 32'(ref_div), 32'h2A5B);
    chk("R4 abp", 32'(abp), 1);
    chk("R4 test", 32'(test), 2);
    chk("R11 ldp with reserved set", 32'(ldp), 1);

    // R5, R11: feedback latch with bits 23:22 and 7:2 set
    write_word({2'b11, 1'b1, 13'h1ABC, 6'h3F, 2'b01});
    chk("R5 fb_div", 32'(fb_div), 32'h1ABC);
    chk("R5 gain", 32'(gain), 1);

    // R6, R8: function latch, no init pulse, others kept
    base = init_hi;
    write_word(mk_fn(2'b10, 1, 0, 3'd5, 4'h9, 3'd3, 3'd6, 1, 4'hF));
    chk("R6 fields", 32'({crst, pda, mux, tmr, cur1, cur2, pdb}),
        32'({1'b1, 1'b0, 3'd5, 4'h9, 3'd3, 3'd6, 1'b1}));
    chk("R6 no init pulse", 32'(init_hi - base), 0);
    chk("R8 ref kept", 32'(ref_div), 32'h2A5B);
    chk("R8 fb kept", 32'(fb_div), 32'h1ABC);

    // R7: initialization latch, single pulse
    base = init_hi;
    write_word(mk_fn(2'b11, 0, 1, 3'd2, 4'h4, 3'd7, 3'd1, 0, 4'h0));
    chk("R7 fields", 32'({crst, pda, mux, tmr, cur1, cur2, pdb}),
        32'({1'b0, 1'b1, 3'd2, 4'h4, 3'd7, 3'd1, 1'b0}));
    chk("R7 pulse cycles", 32'(init_hi - base), 1);
    chk("R8 fb kept after init", 32'(fb_div), 32'h1ABC);

    // R3: shifting without a load edge changes nothing
    send_bits({40'd0, mk_ref(14'h0111, 2'b11, 2'b11, 1'b0, 3'b000)}, 24);
    wait_n(4);
    chk("R3 ref unchanged", 32'(ref_div), 32'h2A5B);
    chk("R3 mux unchanged", 32'(mux), 2);

    // R2: extra leading bits fall out; only the last 24 count
    send_bits({34'd0, 6'b101101, mk_ref(14'h13C7, 2'b10, 2'b00, 1'b0, 3'b000)}, 30);
    commit();
    chk("R2 ref_div last 24", 32'(ref_div), 32'h13C7);
    chk("R2 abp last 24", 32'(abp), 2);

    // R9: latency of a commit counted in falling edges
    send_bits({40'd0, mk_ref(14'h0F0F, 2'b00, 2'b01, 1'b1, 3'b000)}, 24);
    le = 1'b1;
    wait_n(1); chk("R9 old after 1 edge", 32'(ref_div), 32'h13C7);
    wait_n(1); chk("R9 old after 2 edges", 32'(ref_div), 32'h13C7);
    wait_n(1); chk("R9 new after 3 edges", 32'(ref_div), 32'h0F0F);
    le = 1'b0; wait_n(3);

    // R10: load enable held high commits once only
    wa = mk_ref(14'h0AAA, 2'b00, 2'b00, 1'b0, 3'b000);
    wb = mk_ref(14'h1555, 2'b11, 2'b00, 1'b0, 3'b000);
    send_bits({40'd0, wa}, 24);
    le = 1'b1; wait_n(3);
    send_bits({40'd0, wb}, 24);
    chk("R10 single commit while high", 32'(ref_div), 32'h0AAA);
    le = 1'b0; wait_n(3);
    chk("R10 falling edge no commit", 32'(ref_div), 32'h0AAA);
    le = 1'b1; wait_n(3);
    chk("R10 next rise commits", 32'(ref_div), 32'h1555);
    le = 1'b0; wait_n(3);

    // R1: reset mid-run clears everything
    rst = 1'b1; wait_n(2);
    chk("R1 reset again", 32'({ref_div, fb_div, init_p}), 0);
    rst = 1'b0; wait_n(2);

    done = 1;
    summary();
  end
endmodule